// File: doc/BRIEF.md
# Two-Channel Compare-Match Interval Timer

This block is a memory-mapped interval timer with two independent channels. Each channel owns an up-counter that advances on a prescaled version of the block clock, a compare value, and a control/status halfword. The control/status halfword holds the prescale choice, the interrupt enable and the sticky status flags. A single run register at the bottom of the address map carries one run bit per channel. Software starts or halts a channel by rewriting that register and keeps the other channels' bits as they were.

A build-time parameter picks between two flavours. The narrow flavour has 16-bit counters, registers spaced two bytes apart and one match flag. The wide flavour has 32-bit counters, registers spaced four bytes apart, a match flag, a roll-over flag and a control bit that chooses between clearing on match and free-running. Each channel drives its own level interrupt line.

Typical use: halt the channel, preload the counter with zero and the compare register with the period minus one, write the control halfword, then set the channel's run bit. Each time an interrupt arrives, software clears the flag by writing the control halfword back with the flag bit at zero.

Top module: `cmt_timer_pair`

## Requirements
- R1: After reset the run register, every control/status, counter and compare register read as zero, and both interrupt lines are low.
- R2: The run register is at byte address 0. Register r of channel c (r = 0 control/status, 1 counter, 2 compare) is at byte address (1 + 3c + r)·S, where S is 2 in the narrow flavour and 4 in the wide flavour. Control/status occupies bits 15:0. Counter and compare are 16 bits wide in the narrow flavour and 32 bits wide in the wide flavour. Every other address reads as zero.
- R3: Bit c of the run register makes channel c count. Clearing the bit freezes the counter at its value. Rewriting the register with a running channel's bit still set does not disturb that channel's count or prescale phase.
- R4: A running channel's counter advances once every N clocks, where N = 8·4^p and p is control bits 1:0. The first advance comes N clocks after the run bit is written. Control value 0x0043 in the narrow flavour gives N = 512. Control value 0x01A4 in the wide flavour gives N = 8.
- R5: In clear-on-match mode the counter runs 0 to the compare value inclusive. On the advance that finds the counter equal to the compare value, the counter returns to 0 and the match flag is set. The match flag is bit 7 in the narrow flavour and bit 15 in the wide flavour. The narrow flavour is always in this mode. The wide flavour is in this mode when control bit 8 is one.
- R6: In the wide flavour with control bit 8 at zero, a match sets bit 15 and the counter keeps counting. An advance from all ones to zero that is not a match clear sets the roll-over flag, bit 14.
- R7: A set flag stays set through later matches until software writes a zero to it. Writing a one to a flag keeps its present value, so a write can never set a flag. All other control bits are plain storage and read back as written.
- R8: A channel's interrupt is high exactly while its interrupt enable is one and one of its flags is set, and it rises on the same clock edge as the flag. The enable is bit 6 in the narrow flavour and bit 5 in the wide flavour. Writing zero to control/status drops the interrupt.
- R9: Counter and compare can be written at any time. A counter write takes precedence over an advance in the same cycle. An all-ones compare value gives a full-range period.
- R10: Reads are registered: rd_data shows the addressed register on the clock edge after the cycle in which rd_en is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| rd_en | input | 1 | Read strobe, data appears one cycle later |
| addr | input | ADDR_W | Byte address within the block |
| wr_data | input | 32 | Write data, low bits used for narrower registers |
| rd_data | output | 32 | Registered read data, zero-extended |
| irq | output | NCH | One level interrupt per channel |

## Verification
The bench attacks the edges of counting. Random runs check that the count is the number of elapsed prescale periods modulo the compare value plus one, so a design that drops an extra count on the clear or fails to return to zero leaves the wrong residue. The interrupt is sampled one cycle before and one cycle after the exact match edge at divide-by-512, which catches a prescaler that is one clock early or late. Rewriting the run register while a channel runs would expose a design that restarts the prescaler on every write, because that design loses counts. The flag write semantics, roll-over without clear, the all-ones compare value and the aliasing between the two address spacings would each leave a wrong readback if handled incorrectly.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

  // register index inside one channel window
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_LIMIT = 2'd2
  } cmt_reg_e;

  // write request routed from the decoder to one channel
  typedef struct packed {
    logic        ctrl_we;
    logic        count_we;
    logic        limit_we;
    logic [31:0] wdata;
  } cmt_wreq_t;

endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler #(
  parameter int BASE_LOG2 = 3,
  parameter int SEL_W     = 2,
  localparam int PW       = BASE_LOG2 + 2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PW-1:0] div_q;
  logic [PW-1:0] last;

  // ratio = 2^(BASE_LOG2 + 2*sel)
  always_comb last = PW'((32'd1 << (BASE_LOG2 + 2 * int'(sel))) - 32'd1);

  assign tick = run && (div_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4

endmodule

// File: rtl/cmt_decode.sv
`timescale 1ns/1ps
module cmt_decode import cmt_pkg::*; #(
  parameter bit WIDE32 = 1'b1,
  parameter int NCH    = 2,
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              start_hit,
  output logic [NCH-1:0]    ctrl_hit,
  output logic [NCH-1:0]    count_hit,
  output logic [NCH-1:0]    limit_hit
);

  localparam int STEP   = WIDE32 ? 4 : 2;
  localparam int STRIDE = 3 * STEP;

  assign start_hit = (addr == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = STEP + c * STRIDE;
    assign ctrl_hit[c]  = (addr == ADDR_W'(BASE + int'(REG_CTRL)  * STEP));
    assign count_hit[c] = (addr == ADDR_W'(BASE + int'(REG_COUNT) * STEP));
    assign limit_hit[c] = (addr == ADDR_W'(BASE + int'(REG_LIMIT) * STEP));
  end

endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel import cmt_pkg::*; #(
  parameter bit WIDE32    = 1'b1,
  parameter int BASE_LOG2 = 3,
  localparam int CW       = WIDE32 ? 32 : 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  cmt_wreq_t     wreq,
  output logic [15:0]   ctrl,
  output logic [CW-1:0] count,
  output logic [CW-1:0] limit,
  output logic          irq
);

  localparam int FLAG_POS = WIDE32 ? 15 : 7;
  localparam int WRAP_POS = 14;
  localparam int IE_POS   = WIDE32 ? 5 : 6;
  localparam int PER_POS  = 8;
  localparam logic [15:0] STICKY = WIDE32 ? 16'hC000 : 16'h0080;

  logic          tick;
  logic          at_limit;
  logic          periodic;
  logic          match_ev;
  logic          wrap_ev;
  logic [15:0]   set_vec;
  logic [15:0]   ctrl_d;
  logic [CW-1:0] count_d;
  logic [CW-1:0] limit_d;
  logic          irq_d;

  cmt_prescaler #(.BASE_LOG2(BASE_LOG2), .SEL_W(2)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (ctrl[1:0]),
    .tick (tick)
  );

  if (CW < 32) begin : g_narrow
    logic unused_hi;
    assign unused_hi = ^wreq.wdata[31:CW];
  end

  assign at_limit = (count == limit);
  assign periodic = WIDE32 ? ctrl[PER_POS] : 1'b1;
  assign match_ev = tick && !wreq.count_we && at_limit;
  assign wrap_ev  = WIDE32 && tick && !wreq.count_we && (&count) && !(periodic && at_limit);

  always_comb begin
    set_vec = '0;
    set_vec[FLAG_POS] = match_ev;
    if (WIDE32) set_vec[WRAP_POS] = wrap_ev;

    ctrl_d = ctrl;
    if (wreq.ctrl_we)
      ctrl_d = (wreq.wdata[15:0] & ~STICKY) | (wreq.wdata[15:0] & ctrl & STICKY);
    ctrl_d = ctrl_d | set_vec;

    count_d = count;
    if (wreq.count_we)  count_d = wreq.wdata[CW-1:0];
    else if (tick)      count_d = (periodic && at_limit) ? '0 : count + 1'b1;

    limit_d = wreq.limit_we ? wreq.wdata[CW-1:0] : limit;
    irq_d   = ctrl_d[IE_POS] && (|(ctrl_d & STICKY));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      count <= '0;
      limit <= '0;
      irq   <= 1'b0;
    end else begin
      ctrl  <= ctrl_d;
      count <= count_d;
      limit <= limit_d;
      irq   <= irq_d;
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !wreq.count_we) |=> $stable(count)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctrl[FLAG_POS] && !wreq.ctrl_we) |=> ctrl[FLAG_POS]); // R7

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl[IE_POS]); // R8

  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && periodic && at_limit && !wreq.count_we) |=> (count == '0 && ctrl[FLAG_POS])); // R5

endmodule

// File: rtl/cmt_timer_pair.sv
`timescale 1ns/1ps
module cmt_timer_pair import cmt_pkg::*; #(
  parameter bit WIDE32    = 1'b1,
  parameter int NCH       = 2,
  parameter int ADDR_W    = 6,
  parameter int BASE_LOG2 = 3,
  localparam int CW       = WIDE32 ? 32 : 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic [NCH-1:0]    irq
);

  logic           start_hit;
  logic [NCH-1:0] ctrl_hit;
  logic [NCH-1:0] count_hit;
  logic [NCH-1:0] limit_hit;
  logic [NCH-1:0] run_q;
  logic [15:0]    ctrl_v  [NCH];
  logic [CW-1:0]  count_v [NCH];
  logic [CW-1:0]  limit_v [NCH];
  logic [31:0]    rd_mux;

  cmt_decode #(.WIDE32(WIDE32), .NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr      (addr),
    .start_hit (start_hit),
    .ctrl_hit  (ctrl_hit),
    .count_hit (count_hit),
    .limit_hit (limit_hit)
  );

  // shared run register, one bit per channel
  always_ff @(posedge clk) begin
    if (rst)                     run_q <= '0;
    else if (wr_en && start_hit) run_q <= wr_data[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    cmt_wreq_t wreq_c;
    assign wreq_c = '{ctrl_we:  wr_en && ctrl_hit[c],
                      count_we: wr_en && count_hit[c],
                      limit_we: wr_en && limit_hit[c],
                      wdata:    wr_data};

    cmt_channel #(.WIDE32(WIDE32), .BASE_LOG2(BASE_LOG2)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .run   (run_q[c]),
      .wreq  (wreq_c),
      .ctrl  (ctrl_v[c]),
      .count (count_v[c]),
      .limit (limit_v[c]),
      .irq   (irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (start_hit) rd_mux = 32'(run_q);
    for (int c = 0; c < NCH; c++) begin
      if (ctrl_hit[c])  rd_mux = 32'(ctrl_v[c]);
      if (count_hit[c]) rd_mux = 32'(count_v[c]);
      if (limit_hit[c]) rd_mux = 32'(limit_v[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: tb/cmt_timer_pair_tb_top.sv
`timescale 1ns/1ps
module cmt_timer_pair_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we32 = 1'b0, we16 = 1'b0, re32 = 1'b0, re16 = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata32, rdata16;
  logic [1:0]  irq32, irq16;
  bit          f32;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  cmt_timer_pair #(.WIDE32(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(we32), .rd_en(re32), .addr(addr),
    .wr_data(wdata), .rd_data(rdata32), .irq(irq32));

  cmt_timer_pair #(.WIDE32(1'b0)) dut16_i (
    .clk(clk), .rst(rst), .wr_en(we16), .rd_en(re16), .addr(addr),
    .wr_data(wdata), .rd_data(rdata16), .irq(irq16));

  function automatic int a_of(bit w, int ch, int idx);
    return (w ? 4 : 2) * (1 + 3 * ch + idx);
  endfunction

  function automatic int ratio(int code);
    return 8 << (2 * code);
  endfunction

  function automatic logic [31:0] flag_bit(bit w);
    return w ? 32'h8000 : 32'h0080;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = 6'(a); wdata = d; we32 = f32; we16 = !f32;
    @(posedge clk); #1;
    we32 = 1'b0; we16 = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    addr = 6'(a); re32 = f32; re16 = !f32;
    @(posedge clk);
    @(negedge clk);
    d = f32 ? rdata32 : rdata16;
    re32 = 1'b0; re16 = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic cur_irq(int ch);
    return f32 ? irq32[ch] : irq16[ch];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state in both flavours
    for (int w = 0; w < 2; w++) begin
      f32 = w[0];
      rd(0, d); chk("R1 run reg", d, 0);
      for (int ch = 0; ch < 2; ch++)
        for (int r = 0; r < 3; r++) begin
          rd(a_of(f32, ch, r), d); chk("R1 reg", d, 0);
        end
      chk("R1 irq", 32'(f32 ? irq32 : irq16), 0);
    end

    // R2: address map, widths, no aliasing, unmapped reads
    for (int w = 0; w < 2; w++) begin
      f32 = w[0];
      wr(a_of(f32, 0, 2), 32'h1234_5678);
      wr(a_of(f32, 1, 2), 32'h9ABC_DEF0);
      wr(a_of(f32, 1, 1), 32'h0F0F_0F0F);
      wr(a_of(f32, 0, 0), 32'hFFFF_3C0C);
      rd(a_of(f32, 0, 2), d); chk("R2 ch0 compare", d, f32 ? 32'h1234_5678 : 32'h5678);
      rd(a_of(f32, 1, 2), d); chk("R2 ch1 compare", d, f32 ? 32'h9ABC_DEF0 : 32'hDEF0);
      rd(a_of(f32, 1, 1), d); chk("R2 ch1 counter", d, f32 ? 32'h0F0F_0F0F : 32'h0F0F);
      rd(a_of(f32, 0, 1), d); chk("R2 ch0 counter", d, 0);
      rd(a_of(f32, 0, 0), d); chk("R2 R7 ctrl storage", d, 32'h3C0C);
      rd(f32 ? 2 : 14, d);    chk("R2 unmapped", d, 0);
      wr(a_of(f32, 0, 0), 0);
      wr(a_of(f32, 1, 1), 0);
    end

    // R4 R5 R8: narrow flavour, 0x43 -> /512, exact interrupt edge
    f32 = 1'b0;
    wr(a_of(0, 0, 1), 0);
    wr(a_of(0, 0, 2), 2);
    wr(a_of(0, 0, 0), 32'h0043);
    wr(0, 1);
    idle(1536);
    chk("R4 irq before match edge", 32'(cur_irq(0)), 0);
    idle(1);
    chk("R5 R8 irq at match edge", 32'(cur_irq(0)), 1);
    wr(0, 0);
    rd(a_of(0, 0, 1), d); chk("R5 counter back to zero", d, 0);
    rd(a_of(0, 0, 0), d); chk("R5 flag bit7", d, 32'h00C3);
    wr(a_of(0, 0, 0), 32'h0043);
    chk("R7 flag cleared irq low", 32'(cur_irq(0)), 0);

    // R3 R4: rewriting run register keeps running channel undisturbed (wide, 0x1A4)
    f32 = 1'b1;
    for (int ch = 0; ch < 2; ch++) begin
      wr(a_of(1, ch, 1), 0);
      wr(a_of(1, ch, 2), 1000);
      wr(a_of(1, ch, 0), 32'h01A4);
    end
    wr(0, 1);
    idle(20);
    wr(0, 3);
    idle(30);
    wr(0, 0);
    rd(a_of(1, 0, 1), d); chk("R3 ch0 uninterrupted", d, 52 / 8);
    rd(a_of(1, 1, 1), d); chk("R3 ch1 count", d, 31 / 8);
    idle(50);
    rd(a_of(1, 0, 1), d); chk("R3 halted holds", d, 52 / 8);
    wr(0, 2);
    rd(0, d); chk("R3 run reg readback", d, 2);
    wr(0, 0);

    // R6: wide free-running roll-over, then match without clear
    wr(a_of(1, 0, 2), 32'h10);
    wr(a_of(1, 0, 1), 32'hFFFF_FFFF);
    wr(a_of(1, 0, 0), 32'h00A4);
    wr(0, 1); idle(7); wr(0, 0);
    rd(a_of(1, 0, 1), d); chk("R6 rolled to zero", d, 0);
    rd(a_of(1, 0, 0), d); chk("R6 wrap flag bit14", d, 32'h40A4);
    chk("R6 R8 irq from wrap flag", 32'(cur_irq(0)), 1);
    wr(a_of(1, 0, 0), 32'h00A4);
    wr(a_of(1, 0, 1), 0);
    wr(a_of(1, 0, 2), 2);
    wr(0, 1); idle(39); wr(0, 0);
    rd(a_of(1, 0, 1), d); chk("R6 counts past compare", d, 5);
    rd(a_of(1, 0, 0), d); chk("R6 match flag only", d, 32'h80A4);
    wr(a_of(1, 0, 0), 32'hC0A4);
    rd(a_of(1, 0, 0), d); chk("R7 write one keeps flag", d, 32'h80A4);
    wr(a_of(1, 0, 0), 0);
    chk("R8 zero ctrl drops irq", 32'(cur_irq(0)), 0);
    wr(a_of(1, 0, 0), 32'hC000);
    rd(a_of(1, 0, 0), d); chk("R7 write one cannot set", d, 0);

    // R9: narrow full-range compare
    f32 = 1'b0;
    wr(a_of(0, 1, 2), 32'hFFFF);
    wr(a_of(0, 1, 1), 32'hFFFE);
    wr(a_of(0, 1, 0), 32'h0040);
    wr(0, 2); idle(15); wr(0, 0);
    rd(a_of(0, 1, 1), d); chk("R9 all-ones compare wraps", d, 0);
    rd(a_of(0, 1, 0), d); chk("R9 flag at full range", d, 32'h00C0);
    chk("R8 narrow irq", 32'(cur_irq(1)), 1);
    wr(a_of(0, 1, 0), 0);
    chk("R8 narrow irq cleared", 32'(cur_irq(1)), 0);

    // R4 R5 R7 R8 R10: random periodic runs in both flavours
    for (int it = 0; it < 24; it++) begin
      int ch, cor, code, ie, k, n, t;
      logic [31:0] csr, exp_csr;
      logic        flag;
      f32  = it[0];
      ch   = $urandom_range(0, 1);
      cor  = $urandom_range(0, 7);
      code = $urandom_range(0, 1);
      ie   = $urandom_range(0, 1);
      k    = $urandom_range(0, 500);
      n    = ratio(code);
      csr  = f32 ? (32'h0184 | 32'(ie << 5) | 32'(code)) : (32'(ie << 6) | 32'(code));
      wr(a_of(f32, ch, 1), 0);
      wr(a_of(f32, ch, 2), 32'(cor));
      wr(a_of(f32, ch, 0), csr);
      wr(0, 32'(1 << ch));
      idle(k);
      wr(0, 0);
      t = (k + 1) / n;
      flag = (t > cor);
      exp_csr = csr | (flag ? flag_bit(f32) : 32'h0);
      rd(a_of(f32, ch, 1), d); chk("R4 R5 R10 random count", d, 32'(t % (cor + 1)));
      rd(a_of(f32, ch, 0), d); chk("R5 R7 random flag", d, exp_csr);
      chk("R8 random irq", 32'(cur_irq(ch)), 32'(ie != 0 && flag));
      wr(a_of(f32, ch, 0), csr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule